// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block is the digital guard that sits between four half-bridge power switches and the rest of an audio amplifier. It watches overcurrent flags from each half-bridge, a junction-temperature comparator pair, undervoltage flags for the analog rail and the two power rails, a power-on-reset busy flag, an asynchronous active-low reset and an active-low power-down request. From these it produces one enable per half-bridge (0 = high impedance, 1 = drive) and an enable for the noise shaper.

A fault anywhere shuts all four half-bridges off together. Each fault class then has its own release rule. Overcurrent is latched and is released only after a programmable run of clean cycles. Over-temperature is released only when the cooler threshold is reported. Undervoltage gates the outputs directly for as long as it lasts. Power-down first stops the noise shaper and then releases the bridges after a fixed stop interval. When paired-bridge mode is strapped, an overcurrent on either member of a pair drops that pair in the same cycle. Sticky status bits record overcurrent, over-temperature and undervoltage until software clears them.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: While `rstN` is low, `bridgeEn` is 0000, `shaperOn` is 0 and all status bits are 0, taking effect without a clock edge. After release with `pdnN` high and no faults, `bridgeEn` becomes 1111 and `shaperOn` becomes 1 after the first clock edge.
- R2: Any bit of `ocFlag` sampled high at a clock edge makes `bridgeEn` 0000 from that edge on, whichever half-bridge raised it.
- R3: The overcurrent shutdown is released at the edge that completes `cleanCount` consecutive sampled cycles with `ocFlag` all zero. A flag seen during the count restarts it.
- R4: `otTrip` sampled high makes `bridgeEn` 0000 from that edge on. The outputs stay off until `otCool` is sampled high, and then return at that edge. `otCool` on its own changes nothing.
- R5: `uvAnalog`, `uvPwrAB`, `uvPwrCD` or `porBusy` high forces `bridgeEn` to 0000 in the same cycle with no clock edge needed. The outputs return as soon as all of these are low.
- R6: `pdnN` sampled low drops `shaperOn` at that edge. `bridgeEn` stays driven for STOP_LEN (default 8) further edges and then goes to 0000. `pdnN` high while stopped re-enables both at the next edge.
- R7: With `pbtlMode` high, an overcurrent flag on bridge 2k or 2k+1 clears both `bridgeEn[2k]` and `bridgeEn[2k+1]` in the same cycle, before the shared latch acts.
- R8: With `pbtlMode` low, `bridgeEn` is always 0000 or 1111, and a new overcurrent flag does not change it before the next edge.
- R9: `statOc`, `statOt` and `statUv` are set at the edge where their fault (`ocFlag` any bit, `otTrip`, any undervoltage flag) is sampled. They stay set after recovery until `statusClr` is sampled high. A fault present in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdnN | input | 1 | Active-low power-down request |
| pbtlMode | input | 1 | Paired-bridge mode strap |
| ocFlag | input | NUM_BRIDGES | Per-half-bridge overcurrent flags |
| otTrip | input | 1 | Temperature above shutdown threshold |
| otCool | input | 1 | Temperature below recovery threshold |
| uvAnalog | input | 1 | Analog rail undervoltage |
| uvPwrAB | input | 1 | Power rail A/B undervoltage |
| uvPwrCD | input | 1 | Power rail C/D undervoltage |
| porBusy | input | 1 | Power-on reset still active |
| cleanCount | input | CLEAN_W | Clean cycles required to release overcurrent |
| statusClr | input | 1 | Clear strobe for sticky status |
| bridgeEn | output | NUM_BRIDGES | Per-half-bridge drive enable (0 = high impedance) |
| shaperOn | output | 1 | Noise shaper enable |
| statOc | output | 1 | Sticky overcurrent status |
| statOt | output | 1 | Sticky over-temperature status |
| statUv | output | 1 | Sticky undervoltage status |

## Verification
The assertions are checked on every cycle. They cover these rules:
- outputs are off whenever a supply flag or the reset-busy flag is up;
- outputs are off on the cycle after any overcurrent or over-temperature flag;
- in normal mode the enables are all on or all off;
- in paired mode a flagged pair is dropped at once;
- the shaper is off after a power-down sample;
- the overcurrent status bit holds until cleared.

Only the directed scenarios can show the timing of recovery. That covers the exact clean-cycle count and its restart after a glitch, the dependence of over-temperature release on the cool indication, the length of the stop interval, and the precedence of a fault over a status clear.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic drive;   // latched-fault and sequence qualified drive
    logic shaper;  // noise shaper may run
    logic ocHit;   // overcurrent seen this cycle
    logic otHit;   // over-temperature seen this cycle
  } ctlCmd_t;
endpackage

// File: rtl/bfs_control.sv
module bfs_control
  import bfs_pkg::*;
#(
  parameter int NUM_BRIDGES = 4,
  parameter int CLEAN_W     = 8,
  parameter int STOP_LEN    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pdnN,
  input  logic [NUM_BRIDGES-1:0] ocFlag,
  input  logic                   otTrip,
  input  logic                   otCool,
  input  logic [CLEAN_W-1:0]     cleanCount,
  output ctlCmd_t                cmd
);
  localparam int STOP_W = (STOP_LEN > 2) ? $clog2(STOP_LEN) : 1;
  localparam logic [STOP_W-1:0] STOP_LAST = STOP_W'(STOP_LEN - 1);

  pwrState_t          state;
  logic [STOP_W-1:0]  stopCnt;
  logic               ocLatch;
  logic [CLEAN_W-1:0] cleanCnt;
  logic               otLatch;
  logic               anyOc;

  assign anyOc = |ocFlag;

  // Power-down stop sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      stopCnt <= '0;
    end else begin
      case (state)
        ST_OFF:  if (pdnN) state <= ST_RUN;
        ST_RUN:  if (!pdnN) begin
                   state   <= ST_STOP;
                   stopCnt <= '0;
                 end
        ST_STOP: if (stopCnt == STOP_LAST) state <= ST_OFF;
                 else stopCnt <= stopCnt + STOP_W'(1);
        default: state <= ST_OFF;
      endcase
    end
  end

  // Overcurrent latch with clean-cycle qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocLatch  <= 1'b0;
      cleanCnt <= '0;
    end else if (anyOc) begin
      ocLatch  <= 1'b1;
      cleanCnt <= '0;
    end else if (ocLatch) begin
      if (({1'b0, cleanCnt} + (CLEAN_W+1)'(1)) >= {1'b0, cleanCount}) begin
        ocLatch  <= 1'b0;
        cleanCnt <= '0;
      end else begin
        cleanCnt <= cleanCnt + CLEAN_W'(1);
      end
    end
  end

  // Over-temperature hysteresis latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       otLatch <= 1'b0;
    else if (otTrip) otLatch <= 1'b1;
    else if (otCool) otLatch <= 1'b0;
  end

  always_comb begin
    cmd.drive  = (state != ST_OFF) && !ocLatch && !otLatch;
    cmd.shaper = (state == ST_RUN);
    cmd.ocHit  = anyOc;
    cmd.otHit  = otTrip;
  end
endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int NUM_BRIDGES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlCmd_t                cmd,
  input  logic [NUM_BRIDGES-1:0] ocFlag,
  input  logic                   pbtlMode,
  input  logic                   uvAnalog,
  input  logic                   uvPwrAB,
  input  logic                   uvPwrCD,
  input  logic                   porBusy,
  input  logic                   statusClr,
  output logic [NUM_BRIDGES-1:0] bridgeEn,
  output logic                   statOc,
  output logic                   statOt,
  output logic                   statUv
);
  localparam int NUM_PAIRS = NUM_BRIDGES / 2;

  logic [NUM_BRIDGES-1:0] pairKill;
  logic                   uvNow;
  logic                   supplyLow;

  assign uvNow     = uvAnalog | uvPwrAB | uvPwrCD;
  assign supplyLow = uvNow | porBusy;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pairHit;
    assign pairHit           = pbtlMode & (ocFlag[2*p] | ocFlag[2*p+1]);
    assign pairKill[2*p]     = pairHit;
    assign pairKill[2*p+1]   = pairHit;
  end

  assign bridgeEn = {NUM_BRIDGES{cmd.drive & ~supplyLow}} & ~pairKill;

  // Sticky status, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statOc <= 1'b0;
      statOt <= 1'b0;
      statUv <= 1'b0;
    end else begin
      statOc <= cmd.ocHit | (statOc & ~statusClr);
      statOt <= cmd.otHit | (statOt & ~statusClr);
      statUv <= uvNow     | (statUv & ~statusClr);
    end
  end
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
  import bfs_pkg::*;
#(
  parameter int NUM_BRIDGES = 4,
  parameter int CLEAN_W     = 8,
  parameter int STOP_LEN    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pdnN,
  input  logic                   pbtlMode,
  input  logic [NUM_BRIDGES-1:0] ocFlag,
  input  logic                   otTrip,
  input  logic                   otCool,
  input  logic                   uvAnalog,
  input  logic                   uvPwrAB,
  input  logic                   uvPwrCD,
  input  logic                   porBusy,
  input  logic [CLEAN_W-1:0]     cleanCount,
  input  logic                   statusClr,
  output logic [NUM_BRIDGES-1:0] bridgeEn,
  output logic                   shaperOn,
  output logic                   statOc,
  output logic                   statOt,
  output logic                   statUv
);
  ctlCmd_t cmd;

  bfs_control #(
    .NUM_BRIDGES(NUM_BRIDGES), .CLEAN_W(CLEAN_W), .STOP_LEN(STOP_LEN)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .pdnN(pdnN), .ocFlag(ocFlag),
    .otTrip(otTrip), .otCool(otCool), .cleanCount(cleanCount), .cmd(cmd)
  );

  bfs_datapath #(.NUM_BRIDGES(NUM_BRIDGES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ocFlag(ocFlag), .pbtlMode(pbtlMode),
    .uvAnalog(uvAnalog), .uvPwrAB(uvPwrAB), .uvPwrCD(uvPwrCD),
    .porBusy(porBusy), .statusClr(statusClr), .bridgeEn(bridgeEn),
    .statOc(statOc), .statOt(statOt), .statUv(statUv)
  );

  assign shaperOn = cmd.shaper;
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int NUM_BRIDGES = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   pdnN,
  input logic                   pbtlMode,
  input logic [NUM_BRIDGES-1:0] ocFlag,
  input logic                   otTrip,
  input logic                   uvAnalog,
  input logic                   uvPwrAB,
  input logic                   uvPwrCD,
  input logic                   porBusy,
  input logic                   statusClr,
  input logic [NUM_BRIDGES-1:0] bridgeEn,
  input logic                   shaperOn,
  input logic                   statOc
);
  assert_oc_all_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|ocFlag) |=> (bridgeEn == '0));

  assert_ot_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    otTrip |=> (bridgeEn == '0));

  assert_supply_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (uvAnalog || uvPwrAB || uvPwrCD || porBusy) |-> (bridgeEn == '0));

  assert_shaper_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pdnN |=> !shaperOn);

  assert_pair_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pbtlMode && (ocFlag[0] || ocFlag[1])) |-> (bridgeEn[1:0] == 2'b00));

  assert_uniform_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pbtlMode |-> ((bridgeEn == '0) || (bridgeEn == '1)));

  assert_sticky_oc_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statOc && !statusClr) |=> statOc);
endmodule

bind bridge_fault_supervisor bfs_checker #(.NUM_BRIDGES(NUM_BRIDGES)) u_chk (
  .clk(clk), .rstN(rstN), .pdnN(pdnN), .pbtlMode(pbtlMode), .ocFlag(ocFlag),
  .otTrip(otTrip), .uvAnalog(uvAnalog), .uvPwrAB(uvPwrAB), .uvPwrCD(uvPwrCD),
  .porBusy(porBusy), .statusClr(statusClr), .bridgeEn(bridgeEn),
  .shaperOn(shaperOn), .statOc(statOc)
);

// File: tb/bridge_fault_supervisor_tb.sv
module bridge_fault_supervisor_tb;
  localparam int NB = 4;
  localparam int CW = 8;
  localparam int SL = 8;

  logic clk = 1'b0;
  logic rstN, pdnN, pbtlMode, otTrip, otCool;
  logic uvAnalog, uvPwrAB, uvPwrCD, porBusy, statusClr;
  logic [NB-1:0] ocFlag;
  logic [CW-1:0] cleanCount;
  logic [NB-1:0] bridgeEn;
  logic shaperOn, statOc, statOt, statUv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bridge_fault_supervisor #(.NUM_BRIDGES(NB), .CLEAN_W(CW), .STOP_LEN(SL)) u_dut (
    .clk(clk), .rstN(rstN), .pdnN(pdnN), .pbtlMode(pbtlMode), .ocFlag(ocFlag),
    .otTrip(otTrip), .otCool(otCool), .uvAnalog(uvAnalog), .uvPwrAB(uvPwrAB),
    .uvPwrCD(uvPwrCD), .porBusy(porBusy), .cleanCount(cleanCount),
    .statusClr(statusClr), .bridgeEn(bridgeEn), .shaperOn(shaperOn),
    .statOc(statOc), .statOt(statOt), .statUv(statUv)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic testReset();
    check("R1 enables in reset", 32'(bridgeEn), 32'h0);
    check("R1 shaper in reset", 32'(shaperOn), 32'h0);
    check("R1 status in reset", {29'd0, statOc, statOt, statUv}, 32'h0);
    rstN = 1'b1;
    tick();
    check("R1 enables after release", 32'(bridgeEn), 32'hF);
    check("R1 shaper after release", 32'(shaperOn), 32'h1);
  endtask

  task automatic testOcBtl();
    ocFlag = 4'b0100;
    #1 check("R8 no same-cycle drop", 32'(bridgeEn), 32'hF);
    tick();
    check("R2 all off on one flag", 32'(bridgeEn), 32'h0);
    check("R9 statOc set", 32'(statOc), 32'h1);
    ocFlag = '0;
    repeat (3) tick();
    check("R3 still held before count", 32'(bridgeEn), 32'h0);
    tick();
    check("R3 released after count", 32'(bridgeEn), 32'hF);
  endtask

  task automatic testOcGlitch();
    ocFlag = 4'b1000;
    tick();
    ocFlag = '0;
    repeat (2) tick();
    ocFlag = 4'b0010;
    tick();
    ocFlag = '0;
    repeat (3) tick();
    check("R3 glitch restarts count", 32'(bridgeEn), 32'h0);
    tick();
    check("R3 release after restart", 32'(bridgeEn), 32'hF);
  endtask

  task automatic testPbtl();
    pbtlMode = 1'b1;
    ocFlag   = 4'b0001;
    #1 check("R7 pair AB dropped", 32'(bridgeEn), 32'hC);
    tick();
    check("R2 all off in paired mode", 32'(bridgeEn), 32'h0);
    ocFlag = '0;
    repeat (4) tick();
    check("R3 paired recovery", 32'(bridgeEn), 32'hF);
    ocFlag = 4'b1000;
    #1 check("R7 pair CD dropped", 32'(bridgeEn), 32'h3);
    tick();
    ocFlag = '0;
    repeat (4) tick();
    pbtlMode = 1'b0;
    check("R3 paired recovery CD", 32'(bridgeEn), 32'hF);
  endtask

  task automatic testOt();
    otCool = 1'b1;
    tick();
    otCool = 1'b0;
    check("R4 cool alone no effect", 32'(bridgeEn), 32'hF);
    otTrip = 1'b1;
    tick();
    otTrip = 1'b0;
    check("R4 trip shuts down", 32'(bridgeEn), 32'h0);
    check("R9 statOt set", 32'(statOt), 32'h1);
    repeat (3) tick();
    check("R4 held without cool", 32'(bridgeEn), 32'h0);
    otCool = 1'b1;
    tick();
    otCool = 1'b0;
    check("R4 cool releases", 32'(bridgeEn), 32'hF);
  endtask

  task automatic testUv();
    uvPwrCD = 1'b1;
    #1 check("R5 rail low immediate off", 32'(bridgeEn), 32'h0);
    tick();
    check("R9 statUv set", 32'(statUv), 32'h1);
    uvPwrCD = 1'b0;
    #1 check("R5 rail recovered", 32'(bridgeEn), 32'hF);
    porBusy = 1'b1;
    #1 check("R5 por busy off", 32'(bridgeEn), 32'h0);
    porBusy = 1'b0;
    #1 check("R5 por done", 32'(bridgeEn), 32'hF);
    tick();
  endtask

  task automatic testStatus();
    check("R9 bits sticky after recovery", {29'd0, statOc, statOt, statUv}, 32'h7);
    statusClr = 1'b1;
    tick();
    statusClr = 1'b0;
    check("R9 cleared", {29'd0, statOc, statOt, statUv}, 32'h0);
    uvAnalog  = 1'b1;
    statusClr = 1'b1;
    tick();
    uvAnalog = 1'b0;
    check("R9 set wins over clear", 32'(statUv), 32'h1);
    tick();
    statusClr = 1'b0;
    check("R9 clear after fault gone", 32'(statUv), 32'h0);
  endtask

  task automatic testPdn();
    pdnN = 1'b0;
    tick();
    check("R6 shaper stops first", 32'(shaperOn), 32'h0);
    check("R6 bridges still driven", 32'(bridgeEn), 32'hF);
    repeat (SL - 1) tick();
    check("R6 driven through stop", 32'(bridgeEn), 32'hF);
    tick();
    check("R6 released after stop", 32'(bridgeEn), 32'h0);
    pdnN = 1'b1;
    tick();
    check("R6 restart enables", 32'(bridgeEn), 32'hF);
    check("R6 restart shaper", 32'(shaperOn), 32'h1);
  endtask

  task automatic testAsyncReset();
    #5 rstN = 1'b0;
    #1 check("R1 async reset off", 32'(bridgeEn), 32'h0);
    tick();
    rstN = 1'b1;
    tick();
    check("R1 back after reset", 32'(bridgeEn), 32'hF);
  endtask

  initial begin
    rstN = 1'b0; pdnN = 1'b1; pbtlMode = 1'b0; ocFlag = '0;
    otTrip = 1'b0; otCool = 1'b0; uvAnalog = 1'b0; uvPwrAB = 1'b0;
    uvPwrCD = 1'b0; porBusy = 1'b0; statusClr = 1'b0; cleanCount = CW'(4);
    repeat (3) tick();
    testReset();
    testOcBtl();
    testOcGlitch();
    testPbtl();
    testOt();
    testUv();
    testStatus();
    testPdn();
    testAsyncReset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule